// File: doc/BRIEF.md
# Nonvolatile Byte Memory Register Interface

This block sits on a byte-wide CPU register bus and gives software control over a 4096-byte on-chip nonvolatile store. The bus has four registers: two address bytes, a data byte and a control byte. Software reads a location by loading the address and setting a read request. A write has two steps. Software first sets a master-enable bit, which stays set for only a few clocks. Within that short window it sets the write strobe. This two-step sequence makes it unlikely that a stray store corrupts the memory.

A started write captures the address and data, and it holds the strobe bit high for a parameterised number of clocks. The byte is committed to the array at the end of that time. A level ready interrupt is raised whenever no write is in flight, provided both the local enable and the global interrupt enable are set. An input from a neighbouring flash self-programming unit blocks new writes while that unit is busy.

Top module: `nvm_regif`

## Requirements
- R1: After reset the data register reads 0x00, the control register reads 0x00 and irq_o is low.
- R2: The 12-bit address is written through select 0 (bits 7:0) and select 1 (bits 11:8, taken from write data bits 3:0). Reading select 0 returns the low byte. Reading select 1 returns the high nibble with bits 7:4 as zero. The address has no reset value.
- R3: Select 3 is the control register. Bit 3 is the ready-interrupt enable, bit 2 is master-enable, bit 1 is the write strobe/busy bit and bit 0 is the read request. Bits 7:4 always read zero.
- R4: A control write with bit 2 = 1 and bit 1 = 0 sets master-enable. A strobe write issued on the 1st to 4th clock after that setting write is accepted. One issued on the 5th clock is ignored. Master-enable reads 1 for exactly 4 cycles unless it is consumed earlier.
- R5: A control write with bit 1 = 1 while master-enable is 0 starts no write.
- R6: An accepted strobe sets bit 1, which reads 1 for WR_CYCLES (default 16) cycles and then 0. The array then holds the data byte at the address that were current at the strobe.
- R7: A strobe while a write is in progress is ignored. The busy time is not extended and the captured address and data are not replaced.
- R8: A strobe while flash_busy_i is high is ignored.
- R9: A control write with bit 0 = 1 while no write is busy sets bit 0 for one cycle. On the next clock the data register is loaded from the array at the current address and bit 0 clears. A read request while busy is ignored and leaves bit 0 and the data register unchanged.
- R10: irq_o is high exactly when bit 3 is 1, gie_i is 1 and bit 1 is 0.
- R11: An accepted strobe clears master-enable in the same clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_sel_i | input | 2 | Register select: 0 addr low, 1 addr high, 2 data, 3 control |
| reg_we_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Read data of the selected register |
| gie_i | input | 1 | Global interrupt enable |
| flash_busy_i | input | 1 | Flash self-programming in progress |
| irq_o | output | 1 | Ready interrupt, level |

## Verification
The assertions take for granted that software never sets master-enable and the strobe in the same control write, and that flash_busy_i changes only between clocks. The stimulus keeps to these limits. It writes both address bytes before it issues any read or write through the address. It only reads back array locations it has written earlier, so no uninitialised memory cell reaches a compared output. It steps flash_busy_i and gie_i on the inactive clock edge, the same way it drives the bus.

// File: rtl/nvm_pkg.sv
package nvm_pkg;
  typedef enum logic [1:0] {
    SEL_ADDR_LO = 2'd0,
    SEL_ADDR_HI = 2'd1,
    SEL_DATA    = 2'd2,
    SEL_CTRL    = 2'd3
  } reg_sel_e;

  localparam int unsigned CTRL_RIE = 3;
  localparam int unsigned CTRL_MWE = 2;
  localparam int unsigned CTRL_WE  = 1;
  localparam int unsigned CTRL_RE  = 0;
  localparam int unsigned ARM_SPAN = 4;
endpackage

// File: rtl/nvm_arm_timer.sv
module nvm_arm_timer #(
  parameter int unsigned SPAN = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic arm_i,
  input  logic consume_i,
  output logic armed_o
);
  localparam int unsigned CW = $clog2(SPAN + 1);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (arm_i)           cnt_q <= CW'(SPAN);
    else if (consume_i)       cnt_q <= '0;
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign armed_o = (cnt_q != '0);
endmodule

// File: rtl/nvm_write_engine.sv
module nvm_write_engine #(
  parameter int unsigned AW        = 12,
  parameter int unsigned WR_CYCLES = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [AW-1:0] addr_i,
  input  logic [7:0]    data_i,
  output logic          busy_o,
  output logic          commit_o,
  output logic [AW-1:0] commit_addr_o,
  output logic [7:0]    commit_data_o
);
  localparam int unsigned CW = $clog2(WR_CYCLES + 1);
  logic [CW-1:0] left_q;
  logic [AW-1:0] addr_q;
  logic [7:0]    data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              left_q <= '0;
    else if (start_i)         left_q <= CW'(WR_CYCLES);
    else if (left_q != '0)    left_q <= left_q - 1'b1;
  end

  // snapshot so software may reload address/data during the busy time
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      data_q <= '0;
    end else if (start_i) begin
      addr_q <= addr_i;
      data_q <= data_i;
    end
  end

  assign busy_o        = (left_q != '0);
  assign commit_o      = (left_q == CW'(1));
  assign commit_addr_o = addr_q;
  assign commit_data_o = data_q;
endmodule

// File: rtl/nvm_array.sv
module nvm_array #(
  parameter int unsigned DEPTH = 4096,
  parameter int unsigned AW    = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [7:0]    wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [7:0]    rdata_o
);
  logic [7:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/nvm_regif.sv
module nvm_regif #(
  parameter int unsigned DEPTH     = 4096,
  parameter int unsigned WR_CYCLES = 16
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] reg_sel_i,
  input  logic       reg_we_i,
  input  logic [7:0] reg_wdata_i,
  output logic [7:0] reg_rdata_o,
  input  logic       gie_i,
  input  logic       flash_busy_i,
  output logic       irq_o
);
  import nvm_pkg::*;

  localparam int unsigned AW  = $clog2(DEPTH);
  localparam int unsigned HIW = AW - 8;

  logic [AW-1:0] addr_q;
  logic [7:0]    data_q;
  logic          rie_q, re_q;
  logic          armed, wr_busy, commit;
  logic [AW-1:0] commit_addr;
  logic [7:0]    commit_data, arr_rdata;
  logic          ctrl_wr, arm_req, start, rd_req;
  reg_sel_e      sel;

  assign sel     = reg_sel_e'(reg_sel_i);
  assign ctrl_wr = reg_we_i && (sel == SEL_CTRL);
  assign arm_req = ctrl_wr && reg_wdata_i[CTRL_MWE] && !reg_wdata_i[CTRL_WE];
  assign start   = ctrl_wr && reg_wdata_i[CTRL_WE] && armed && !wr_busy && !flash_busy_i;
  assign rd_req  = ctrl_wr && reg_wdata_i[CTRL_RE] && !wr_busy && !start;

  // address has no reset: software must load it first
  always_ff @(posedge clk_i) begin
    if (reg_we_i && sel == SEL_ADDR_LO) addr_q[7:0]    <= reg_wdata_i;
    if (reg_we_i && sel == SEL_ADDR_HI) addr_q[AW-1:8] <= reg_wdata_i[HIW-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '0;
      rie_q  <= 1'b0;
      re_q   <= 1'b0;
    end else begin
      if (re_q)                                data_q <= arr_rdata;
      else if (reg_we_i && sel == SEL_DATA)    data_q <= reg_wdata_i;
      if (ctrl_wr) rie_q <= reg_wdata_i[CTRL_RIE];
      re_q <= rd_req;
    end
  end

  nvm_arm_timer #(.SPAN(ARM_SPAN)) u_arm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .arm_i     (arm_req),
    .consume_i (start),
    .armed_o   (armed)
  );

  nvm_write_engine #(.AW(AW), .WR_CYCLES(WR_CYCLES)) u_eng (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .start_i       (start),
    .addr_i        (addr_q),
    .data_i        (data_q),
    .busy_o        (wr_busy),
    .commit_o      (commit),
    .commit_addr_o (commit_addr),
    .commit_data_o (commit_data)
  );

  nvm_array #(.DEPTH(DEPTH), .AW(AW)) u_mem (
    .clk_i   (clk_i),
    .we_i    (commit),
    .waddr_i (commit_addr),
    .wdata_i (commit_data),
    .raddr_i (addr_q),
    .rdata_o (arr_rdata)
  );

  always_comb begin
    unique case (sel)
      SEL_ADDR_LO: reg_rdata_o = addr_q[7:0];
      SEL_ADDR_HI: reg_rdata_o = 8'(addr_q[AW-1:8]);
      SEL_DATA:    reg_rdata_o = data_q;
      default:     reg_rdata_o = {4'b0, rie_q, armed, wr_busy, re_q};
    endcase
  end

  assign irq_o = rie_q && gie_i && !wr_busy;
endmodule

// File: rtl/nvm_regif_chk.sv
module nvm_regif_chk #(
  parameter int unsigned WR_CYCLES = 16
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [1:0] reg_sel_i,
  input logic       reg_we_i,
  input logic [1:0] ctrl_bits,
  input logic [3:0] rdata_hi,
  input logic       gie_i,
  input logic       flash_busy_i,
  input logic       irq_o,
  input logic       armed,
  input logic       busy,
  input logic       re_q,
  input logic       rie_q
);
  logic        arm_wr;
  logic [31:0] len_q;

  assign arm_wr = reg_we_i && reg_sel_i == 2'd3 && ctrl_bits[1] && !ctrl_bits[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   len_q <= '0;
    else if (busy) len_q <= len_q + 1;
    else           len_q <= '0;
  end

  AST_ARM_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni) arm_wr |=> armed); // R4
  AST_ARM_NO_SELF_SET: assert property (@(posedge clk_i) disable iff (!rst_ni) (!armed && !arm_wr) |=> !armed); // R4
  AST_NO_START_UNARMED: assert property (@(posedge clk_i) disable iff (!rst_ni) (!armed && !busy) |=> !busy); // R5
  AST_FLASH_BLOCK: assert property (@(posedge clk_i) disable iff (!rst_ni) (flash_busy_i && !busy) |=> !busy); // R8
  AST_BUSY_LEN: assert property (@(posedge clk_i) disable iff (!rst_ni) $fell(busy) |-> (len_q == WR_CYCLES)); // R6
  AST_READ_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni) re_q |=> !re_q); // R9
  AST_IRQ_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni) busy |-> !irq_o); // R10
  AST_IRQ_READY: assert property (@(posedge clk_i) disable iff (!rst_ni) (!busy && rie_q && gie_i) |-> irq_o); // R10
  AST_CTRL_UPPER: assert property (@(posedge clk_i) disable iff (!rst_ni) (reg_sel_i == 2'd3) |-> (rdata_hi == 4'h0)); // R3
  AST_STROBE_DISARMS: assert property (@(posedge clk_i) disable iff (!rst_ni) $rose(busy) |-> !armed); // R11
endmodule

bind nvm_regif nvm_regif_chk #(.WR_CYCLES(WR_CYCLES)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .reg_sel_i    (reg_sel_i),
  .reg_we_i     (reg_we_i),
  .ctrl_bits    (reg_wdata_i[2:1]),
  .rdata_hi     (reg_rdata_o[7:4]),
  .gie_i        (gie_i),
  .flash_busy_i (flash_busy_i),
  .irq_o        (irq_o),
  .armed        (armed),
  .busy         (wr_busy),
  .re_q         (re_q),
  .rie_q        (rie_q)
);

// File: tb/nvm_regif_test.sv
module nvm_regif_test;
  localparam int WR = 16;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [1:0] reg_sel_i = 2'd3;
  logic       reg_we_i = 1'b0;
  logic [7:0] reg_wdata_i = 8'h00;
  logic [7:0] reg_rdata_o;
  logic       gie_i = 1'b0;
  logic       flash_busy_i = 1'b0;
  logic       irq_o;

  int vectors = 0;
  int fails   = 0;
  string req  = "R1";

  // behavioural reference state
  logic [7:0]  mem_m [4096];
  logic [11:0] addr_m;
  logic [11:0] waddr_m;
  logic [7:0]  data_m, wdata_m;
  int          arm_left = 0, busy_left = 0;
  bit          rie_m = 0, re_m = 0;

  always #4 clk_i = ~clk_i;

  nvm_regif #(.WR_CYCLES(WR)) uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .reg_sel_i(reg_sel_i), .reg_we_i(reg_we_i),
    .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o), .gie_i(gie_i),
    .flash_busy_i(flash_busy_i), .irq_o(irq_o)
  );

  task automatic model_step();
    int  n_arm  = (arm_left > 0) ? arm_left - 1 : 0;
    int  n_busy = (busy_left > 0) ? busy_left - 1 : 0;
    bit  n_re   = 0;
    bit  go     = 0;
    if (re_m) data_m = mem_m[addr_m];
    else if (reg_we_i && reg_sel_i == 2'd2) data_m = reg_wdata_i;
    if (busy_left == 1) mem_m[waddr_m] = wdata_m;
    if (reg_we_i && reg_sel_i == 2'd0) addr_m[7:0]  = reg_wdata_i;
    if (reg_we_i && reg_sel_i == 2'd1) addr_m[11:8] = reg_wdata_i[3:0];
    if (reg_we_i && reg_sel_i == 2'd3) begin
      if (reg_wdata_i[2] && !reg_wdata_i[1]) n_arm = 4;
      if (reg_wdata_i[1] && arm_left > 0 && busy_left == 0 && !flash_busy_i) begin
        go = 1; n_busy = WR; n_arm = 0;
        waddr_m = addr_m; wdata_m = (re_m) ? data_m : data_m;
      end
      if (reg_wdata_i[0] && busy_left == 0 && !go) n_re = 1;
      rie_m = reg_wdata_i[3];
    end
    arm_left = n_arm; busy_left = n_busy; re_m = n_re;
  endtask

  function automatic logic [7:0] model_rd(input logic [1:0] s);
    case (s)
      2'd0: return addr_m[7:0];
      2'd1: return {4'h0, addr_m[11:8]};
      2'd2: return data_m;
      default: return {4'h0, rie_m, arm_left > 0, busy_left > 0, re_m};
    endcase
  endfunction

  task automatic compare();
    logic [7:0] e = model_rd(reg_sel_i);
    logic       ei = rie_m && gie_i && busy_left == 0;
    vectors++;
    if (reg_rdata_o !== e) begin
      fails++;
      $display("FAIL %s rdata sel=%0d got %02h exp %02h", req, reg_sel_i, reg_rdata_o, e);
    end
    vectors++;
    if (irq_o !== ei) begin
      fails++;
      $display("FAIL %s irq got %0b exp %0b", req, irq_o, ei);
    end
  endtask

  task automatic cyc();
    @(posedge clk_i);
    model_step();
    @(negedge clk_i);
    reg_we_i = 1'b0;
    compare();
  endtask

  task automatic wr(input logic [1:0] s, input logic [7:0] d);
    reg_sel_i = s; reg_we_i = 1'b1; reg_wdata_i = d;
    cyc();
    reg_sel_i = 2'd3;
  endtask

  task automatic idle(input int n, input logic [1:0] s);
    reg_sel_i = s;
    for (int i = 0; i < n; i++) cyc();
  endtask

  task automatic set_addr(input logic [11:0] a);
    wr(2'd0, a[7:0]);
    wr(2'd1, {4'h0, a[11:8]});
  endtask

  task automatic do_write(input logic [11:0] a, input logic [7:0] d, input int gap);
    set_addr(a);
    wr(2'd2, d);
    wr(2'd3, 8'h04 | {rie_m, 3'b000});
    idle(gap, 2'd3);
    wr(2'd3, 8'h02 | {rie_m, 3'b000});
  endtask

  task automatic do_read(input logic [11:0] a);
    set_addr(a);
    wr(2'd3, 8'h01 | {rie_m, 3'b000});
    idle(2, 2'd3);
    idle(1, 2'd2);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    fails++;
    $display("FAIL watchdog got running exp done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    data_m = 8'h00;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    req = "R1"; compare();
    reg_sel_i = 2'd2; @(negedge clk_i); compare(); reg_sel_i = 2'd3;

    req = "R2"; set_addr(12'hF5A); idle(1, 2'd0); idle(1, 2'd1);
    wr(2'd1, 8'hFF); idle(1, 2'd1);

    req = "R3"; wr(2'd3, 8'hF8); idle(1, 2'd3); wr(2'd3, 8'h00);

    req = "R5"; set_addr(12'h010); wr(2'd2, 8'h11); wr(2'd3, 8'h02); idle(3, 2'd3);

    req = "R4"; do_write(12'h123, 8'hA5, 3); idle(WR + 2, 2'd3);
    req = "R6"; do_read(12'h123);
    req = "R4"; do_write(12'h124, 8'h5A, 0); idle(WR + 2, 2'd3); do_read(12'h124);
    req = "R4"; do_write(12'h125, 8'h77, 4); idle(WR + 2, 2'd3);
    req = "R4"; set_addr(12'h020); wr(2'd3, 8'h04); idle(6, 2'd3);

    req = "R7"; do_write(12'h200, 8'h3C, 1);
    idle(5, 2'd3); set_addr(12'h201); wr(2'd2, 8'hEE);
    wr(2'd3, 8'h04); wr(2'd3, 8'h02); idle(WR, 2'd3);
    req = "R7"; do_read(12'h200);

    req = "R8"; flash_busy_i = 1'b1; do_write(12'h300, 8'h99, 1); idle(3, 2'd3);
    flash_busy_i = 1'b0; idle(2, 2'd3);
    req = "R8"; do_write(12'h300, 8'h99, 1); idle(WR + 1, 2'd3); do_read(12'h300);

    req = "R9"; do_write(12'h400, 8'hC3, 0); idle(2, 2'd3);
    wr(2'd3, 8'h01); idle(2, 2'd3); idle(1, 2'd2); idle(WR, 2'd3);
    req = "R9"; do_read(12'h400); do_read(12'h123);

    req = "R10"; gie_i = 1'b1; wr(2'd3, 8'h08); idle(2, 2'd3);
    do_write(12'h500, 8'h42, 2); idle(WR + 2, 2'd3);
    gie_i = 1'b0; idle(2, 2'd3); gie_i = 1'b1; idle(1, 2'd3);
    req = "R11"; do_write(12'h501, 8'h24, 1); idle(WR + 2, 2'd3);
    do_read(12'h501);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule